// File: doc/BRIEF.md
# Output Virtual-Channel Credit Tracker

This block tracks downstream buffer space for every virtual channel (VC) of one router output port. Each VC has a credit counter. The counter starts full, at the downstream buffer depth. It loses one credit for each flit that is sent into that VC and gains one credit for each credit token that the downstream router returns. From these counters the block produces a registered ready vector, one bit per VC, which the switch allocator uses to decide which requests it may grant.

The allocation and traversal stages are pipelined. A grant from the switch allocator, together with the output VC that the winning flit was given, is captured in a register at the end of the allocation cycle. The counter is charged only on the following clock edge, in the traversal stage. During that one-cycle gap the allocator still sees the old readiness. For this reason a VC is declared ready only while it holds at least two credits, so a flit granted in that gap still finds space downstream. The threshold does not depend on the buffer depth. Arbitration, the crossbar, route computation and VC allocation are outside this block. Grants and VC ids arrive as inputs.

Top module: `vc_credit_tracker`

## Requirements
- R1: While reset is held and right after it is released, every counter equals DEPTH and every ready bit is 1 (DEPTH must be at least 2).
- R2: A ready bit is 1 exactly when its VC holds two or more credits. At one credit or zero credits the bit is 0.
- R3: A grant sampled on a rising edge with `sa_gnt_vld`=1 charges VC `sa_gnt_vc` on the next rising edge. The ready vector reflects the lower count right after that second edge.
- R4: A credit return sampled with `crd_vld`=1 adds one credit to VC `crd_vc` on that same edge. The ready vector reflects the new count right after that edge.
- R5: When a pending charge and a credit return hit the same VC on the same edge, that counter keeps its value.
- R6: When a pending charge and a credit return hit different VCs on the same edge, both updates take effect.
- R7: `sa_gnt_vc` has no effect while `sa_gnt_vld` is 0, and `crd_vc` has no effect while `crd_vld` is 0.
- R8: If grants are issued only to VCs whose ready bit is 1, the number of flits in flight to a VC never exceeds DEPTH. No counter ever drops below zero or rises above DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| sa_gnt_vld | input | 1 | Switch allocator granted a flit to this output port this cycle |
| sa_gnt_vc | input | VCW | Output VC allocated to the winning flit |
| crd_vld | input | 1 | A credit token returned from downstream this cycle |
| crd_vc | input | VCW | VC the returned credit belongs to |
| vc_ready | output | NUM_VC | Registered per-VC ready flags for the switch allocator |

## Verification
A grant appears in the ready vector two edges after the edge that samples it: one edge for the pipeline register and one edge for the counter. A credit return appears after the single edge that samples it. The bench changes inputs on the falling edge and reads `vc_ready` on the next falling edge. Each one-edge step is therefore an exact unit. Each check is placed at the step where the count first crosses the 2-to-1 boundary, so an update arriving one edge early or late flips the compared bit. Counts that cannot be seen directly, such as a held or a lost update, are revealed by a follow-up series of grants that is timed to bring the ready bit down at a known step.

// File: rtl/vct_pkg.sv
package vct_pkg;

   // Kind of update a credit counter applies on a clock edge
   typedef enum logic [1:0] {
      UPD_IDLE = 2'd0,
      UPD_TAKE = 2'd1,
      UPD_GIVE = 2'd2,
      UPD_HOLD = 2'd3
   } upd_e;

   // Readiness needs strictly more credits than this, regardless of depth
   localparam int unsigned READY_FLOOR = 1;

endpackage

// File: rtl/vct_onehot_dec.sv
module vct_onehot_dec #(
   parameter int N   = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          en,
   input  logic [IW-1:0] idx,
   output logic [N-1:0]  hot
);

   for (genvar i = 0; i < N; i++) begin : g_bit
      assign hot[i] = en && (idx == IW'(i));
   end

endmodule

// File: rtl/vct_grant_pipe.sv
module vct_grant_pipe #(
   parameter int NUM_VC = 4,
   localparam int VCW   = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           gnt_vld,
   input  logic [VCW-1:0] gnt_vc,
   output logic           st_vld,
   output logic [VCW-1:0] st_vc
);

   // Allocation/traversal boundary: grant and allocated VC move on together
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_vld <= 1'b0;
         st_vc  <= '0;
      end else begin
         st_vld <= gnt_vld;
         st_vc  <= gnt_vld ? gnt_vc : st_vc;
      end
   end

endmodule

// File: rtl/vct_credit_cnt.sv
module vct_credit_cnt
   import vct_pkg::*;
#(
   parameter int DEPTH = 4,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic          give,
   output logic [CW-1:0] cnt,
   output logic          ready
);

   upd_e          upd;
   logic [CW-1:0] cnt_nxt;

   always_comb begin
      unique case ({give, take})
         2'b01:   upd = UPD_TAKE;
         2'b10:   upd = UPD_GIVE;
         2'b11:   upd = UPD_HOLD;
         default: upd = UPD_IDLE;
      endcase
   end

   always_comb begin
      unique case (upd)
         UPD_TAKE: cnt_nxt = cnt - CW'(1);
         UPD_GIVE: cnt_nxt = cnt + CW'(1);
         default:  cnt_nxt = cnt;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= CW'(DEPTH);
         ready <= 1'b1;
      end else begin
         cnt   <= cnt_nxt;
         ready <= (cnt_nxt > CW'(READY_FLOOR));
      end
   end

endmodule

// File: rtl/vc_credit_tracker.sv
module vc_credit_tracker #(
   parameter int NUM_VC = 4,
   parameter int DEPTH  = 4,
   localparam int VCW   = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sa_gnt_vld,
   input  logic [VCW-1:0]    sa_gnt_vc,
   input  logic              crd_vld,
   input  logic [VCW-1:0]    crd_vc,
   output logic [NUM_VC-1:0] vc_ready
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("vc_credit_tracker: DEPTH must be at least 2");
   end
   if (NUM_VC < 1) begin : g_bad_vc
      $error("vc_credit_tracker: NUM_VC must be at least 1");
   end

   logic                       pipe_vld;
   logic [VCW-1:0]             pipe_vc;
   logic [NUM_VC-1:0]          take_hot;
   logic [NUM_VC-1:0]          give_hot;
   logic [NUM_VC-1:0][CW-1:0]  cnt_all;

   vct_grant_pipe #(.NUM_VC(NUM_VC)) u_pipe (
      .clk     (clk),
      .rst_n   (rst_n),
      .gnt_vld (sa_gnt_vld),
      .gnt_vc  (sa_gnt_vc),
      .st_vld  (pipe_vld),
      .st_vc   (pipe_vc)
   );

   vct_onehot_dec #(.N(NUM_VC)) u_take_dec (
      .en  (pipe_vld),
      .idx (pipe_vc),
      .hot (take_hot)
   );

   vct_onehot_dec #(.N(NUM_VC)) u_give_dec (
      .en  (crd_vld),
      .idx (crd_vc),
      .hot (give_hot)
   );

   for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
      vct_credit_cnt #(.DEPTH(DEPTH)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .take  (take_hot[v]),
         .give  (give_hot[v]),
         .cnt   (cnt_all[v]),
         .ready (vc_ready[v])
      );
   end

endmodule

// File: rtl/vct_checker.sv
module vct_checker #(
   parameter int NUM_VC = 4,
   parameter int DEPTH  = 4,
   localparam int VCW   = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      gnt_vld,
   input logic [VCW-1:0]            gnt_vc,
   input logic                      crd_vld,
   input logic [VCW-1:0]            crd_vc,
   input logic                      pipe_vld,
   input logic [VCW-1:0]            pipe_vc,
   input logic [NUM_VC-1:0][CW-1:0] cnt_all,
   input logic [NUM_VC-1:0]         vc_ready
);

   logic same_vc;
   assign same_vc = pipe_vld && crd_vld && (pipe_vc == crd_vc);

   // R3
   grant_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_vld |=> (pipe_vld && pipe_vc == $past(gnt_vc)));

   // R3
   charge_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pipe_vld && !same_vc) |=> cnt_all[$past(pipe_vc)] == CW'($past(cnt_all[pipe_vc]) - CW'(1)));

   // R4
   refund_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (crd_vld && !same_vc) |=> cnt_all[$past(crd_vc)] == CW'($past(cnt_all[crd_vc]) + CW'(1)));

   // R5
   collide_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      same_vc |=> cnt_all[$past(crd_vc)] == $past(cnt_all[crd_vc]));

   // R8
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pipe_vld && !same_vc) |-> cnt_all[pipe_vc] != '0);

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (crd_vld && !same_vc) |-> cnt_all[crd_vc] != CW'(DEPTH));

   for (genvar i = 0; i < NUM_VC; i++) begin : g_rdy
      // R2
      ready_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
         vc_ready[i] == (cnt_all[i] > CW'(1)));
   end

endmodule

bind vc_credit_tracker vct_checker #(.NUM_VC(NUM_VC), .DEPTH(DEPTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .gnt_vld  (sa_gnt_vld),
   .gnt_vc   (sa_gnt_vc),
   .crd_vld  (crd_vld),
   .crd_vc   (crd_vc),
   .pipe_vld (pipe_vld),
   .pipe_vc  (pipe_vc),
   .cnt_all  (cnt_all),
   .vc_ready (vc_ready)
);

// File: tb/vc_credit_tracker_tb.sv
module vc_credit_tracker_tb;

   localparam int NUM_VC = 4;
   localparam int DEPTH  = 4;
   localparam int VCW    = 2;
   localparam int LAT    = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              sa_gnt_vld = 1'b0;
   logic [VCW-1:0]    sa_gnt_vc = '0;
   logic              crd_vld = 1'b0;
   logic [VCW-1:0]    crd_vc = '0;
   logic [NUM_VC-1:0] vc_ready;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   vc_credit_tracker #(.NUM_VC(NUM_VC), .DEPTH(DEPTH)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .sa_gnt_vld (sa_gnt_vld),
      .sa_gnt_vc  (sa_gnt_vc),
      .crd_vld    (crd_vld),
      .crd_vc     (crd_vc),
      .vc_ready   (vc_ready)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // One clock: drive after a falling edge, return at the next falling edge
   task automatic step(input logic gv, input int gc, input logic rv, input int rc);
      sa_gnt_vld = gv;
      sa_gnt_vc  = VCW'(gc);
      crd_vld    = rv;
      crd_vc     = VCW'(rc);
      @(negedge clk);
   endtask

   task automatic idle();
      step(1'b0, 0, 1'b0, 0);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      sa_gnt_vld = 1'b0; crd_vld = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1 ready during reset", int'(vc_ready), 'hF);
      rst_n = 1'b1;
      idle();
      chk("R1 ready after reset", int'(vc_ready), 'hF);
   endtask

   task automatic t_charge_and_floor();
      do_reset();
      step(1'b1, 0, 1'b0, 0);
      step(1'b1, 0, 1'b0, 0);
      step(1'b1, 0, 1'b0, 0);
      chk("R3 two credits still ready", int'(vc_ready), 'hF);
      step(1'b1, 0, 1'b0, 0);
      chk("R3 third charge lands one edge late", int'(vc_ready), 'hE);
      idle();
      chk("R2 zero credits not ready", int'(vc_ready), 'hE);
      step(1'b0, 0, 1'b1, 0);
      chk("R2 one credit not ready", int'(vc_ready), 'hE);
      step(1'b0, 0, 1'b1, 0);
      chk("R4 refund makes two credits ready", int'(vc_ready), 'hF);
   endtask

   task automatic t_same_vc_collide();
      do_reset();
      step(1'b1, 1, 1'b0, 0);
      step(1'b1, 1, 1'b0, 0);
      idle();
      chk("R5 setup vc1 at two", int'(vc_ready), 'hF);
      step(1'b1, 1, 1'b0, 0);
      step(1'b0, 0, 1'b1, 1);
      chk("R5 collision keeps count", int'(vc_ready), 'hF);
      step(1'b1, 1, 1'b0, 0);
      idle();
      chk("R5 count was exactly two", int'(vc_ready), 'hD);
   endtask

   task automatic t_split_vc();
      do_reset();
      step(1'b1, 3, 1'b0, 0);
      step(1'b1, 3, 1'b0, 0);
      step(1'b1, 3, 1'b0, 0);
      idle();
      chk("R6 setup vc3 at one", int'(vc_ready), 'h7);
      step(1'b1, 2, 1'b0, 0);
      step(1'b0, 0, 1'b1, 3);
      chk("R6 refund vc3 with charge vc2", int'(vc_ready), 'hF);
      step(1'b1, 2, 1'b0, 0);
      step(1'b1, 2, 1'b0, 0);
      idle();
      chk("R6 vc2 charge was applied", int'(vc_ready), 'hB);
   endtask

   task automatic t_invalid_ignored();
      do_reset();
      for (int k = 0; k < NUM_VC; k++) step(1'b0, k, 1'b0, k);
      chk("R7 invalid ids leave ready", int'(vc_ready), 'hF);
      step(1'b1, 0, 1'b0, 0);
      step(1'b1, 0, 1'b0, 0);
      idle();
      chk("R7 vc0 still had full credits", int'(vc_ready), 'hF);
      step(1'b1, 0, 1'b0, 0);
      idle();
      chk("R7 vc0 at one after three charges", int'(vc_ready), 'hE);
   endtask

   task automatic t_stream();
      logic [LAT-1:0] ret_sr = '0;
      int in_flight = 0;
      int max_fl = 0;
      int sent = 0;
      do_reset();
      for (int k = 0; k < 80; k++) begin
         logic gv;
         logic rv;
         gv = vc_ready[0];
         rv = ret_sr[LAT-1];
         step(gv, 0, rv, 0);
         in_flight += int'(gv) - int'(rv);
         if (in_flight > max_fl) max_fl = in_flight;
         if (gv) sent++;
         ret_sr = {ret_sr[LAT-2:0], gv};
      end
      chk("R8 in-flight bounded by depth", int'(max_fl <= DEPTH), 1);
      chk("R8 stream made progress", int'(sent >= 30), 1);
      for (int k = 0; k < LAT; k++) begin
         step(1'b0, 0, ret_sr[LAT-1], 0);
         ret_sr = {ret_sr[LAT-2:0], 1'b0};
      end
      idle();
      chk("R8 all credits home", int'(vc_ready), 'hF);
   endtask

   initial begin
      @(negedge clk);
      t_charge_and_floor();
      t_same_vc_collide();
      t_split_vc();
      t_invalid_ignored();
      t_stream();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule